// File: doc/BRIEF.md
# Zoned External Bus Read Sequencer

This block runs the read side of an external parallel memory bus for an embedded controller core. The core asks for a byte or a 16-bit word from one of several address zones. The sequencer then steps the bus through its read states, clock by clock. It drives the address, a one-hot zone select, an active-high read strobe and a 3-bit bus-state code. It samples the data bus and returns the assembled value with a single-cycle done pulse.

Each zone has its own configuration:

- data path width, either 8 or 16 bits
- number of internal wait states
- number of hold states
- burst enable, and an extra wait before the burst
- idle-before and idle-after flags

When the core wants a word from an 8-bit zone that allows bursts, a second byte fetch is added after the first. Back-to-back reads to the same zone keep the select asserted. A move to another zone can force one idle cycle.

A request is taken while the sequencer is idle, or in the last state of the current read. A request taken in that last state starts its T1 in the very next cycle, unless an idle cycle is required first.

Top module: `zbus_read_seq`

## Requirements
- R1: A read runs T1, then exactly the zone's configured number of internal waits, then T2. `busState` reads 0 for idle, 1 for T1, 2 for an internal wait, 3 for T2, 4 for the burst wait, 5 for the burst state and 6 for a hold state.
- R2: `rdStrobe` is high only in internal waits, T2, the burst wait and the burst state. It is therefore low in the cycle after T2 (or after the burst state when a burst runs), even when another read follows at once.
- R3: `zoneSel` is one-hot with bit z set for a read to zone z, from T1 through the read's last state. It is all-zero while idle. It stays set without a break when the next read targets the same zone.
- R4: A burst state follows T2 only for a word read from a zone configured 8 bits wide with burst enabled. A single burst-wait state is placed between T2 and the burst state when that zone's burst-wait bit is set.
- R5: `busAddr` equals the request address from T1 through T2. It becomes that address plus one starting with the burst wait if present, or with the burst state otherwise.
- R6: A word from a 16-bit zone returns `busData[15:0]` sampled at the end of T2. A burst returns `busData[7:0]` from T2 as the low byte and from the burst state as the high byte. Every other read returns `busData[7:0]` from T2 zero-extended.
- R7: After T2, or after the burst state, exactly the zone's configured number of hold states follow, with the select still asserted.
- R8: When a request is accepted in the last state of a read to a different zone, exactly one idle cycle with no select is inserted before its T1, if either the finishing zone's idle-after flag or the new zone's idle-before flag is set. No idle cycle is inserted otherwise.
- R9: `reqReady` is high when idle or in the last state of a read. `rspDone` pulses for one cycle in the cycle after that last state, with `rspData` valid in that cycle.
- R10: During reset the bus is idle: state code 0, no select, strobe low, no done, and `reqReady` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core read request present |
| reqZone | input | ZONE_W | Zone index of the request |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqWord | input | 1 | 1 = 16-bit access, 0 = byte access |
| reqReady | output | 1 | Request is taken this cycle if valid |
| cfgWide | input | NUM_ZONES | Per zone: 1 = 16-bit data path |
| cfgWaits | input | NUM_ZONES*WAIT_W | Per zone internal wait count, zone z at bits z*WAIT_W |
| cfgHolds | input | NUM_ZONES*HOLD_W | Per zone hold count, zone z at bits z*HOLD_W |
| cfgBurst | input | NUM_ZONES | Per zone burst enable |
| cfgBurstWait | input | NUM_ZONES | Per zone wait before the burst state |
| cfgIdlePre | input | NUM_ZONES | Per zone idle before entering the zone |
| cfgIdlePost | input | NUM_ZONES | Per zone idle after leaving the zone |
| busAddr | output | ADDR_W | External address bus |
| zoneSel | output | NUM_ZONES | One-hot zone select, active high |
| rdStrobe | output | 1 | Read strobe, active high |
| busState | output | 3 | Current bus state code |
| busData | input | 16 | External data bus |
| rspData | output | 16 | Assembled read data |
| rspDone | output | 1 | One-cycle completion pulse |

## Verification
The zones are configured so that they cover distinct shapes:

- a 16-bit zone with no waits or holds
- an 8-bit zone that bursts with a burst wait, two internal waits, one hold and an idle-after flag
- an 8-bit zone that bursts without a burst wait and carries an idle-before flag
- an 8-bit zone with two holds and no burst

Requests are issued in three ways. Back-to-back runs to one zone separate select continuity from zone switching. Switches between zones separate the cases where an idle cycle is and is not inserted. Requests that arrive after the bus has gone idle separate immediate starts from starts at the end of a read.

Word and byte accesses to each zone separate the burst from single fetches. The data pattern depends on the address, so a wrong burst address or a wrong byte lane shows up in the returned data.

// File: rtl/zbus_pkg.sv
package zbus_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_GAP  = 3'd1,
    S_T1   = 3'd2,
    S_TIW  = 3'd3,
    S_T2   = 3'd4,
    S_TBW  = 3'd5,
    S_T2B  = 3'd6,
    S_HOLD = 3'd7
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic incAddr;
    logic capLow;
    logic capWide;
    logic capHigh;
  } dpCtl_t;

  localparam logic [2:0] BS_IDLE = 3'd0;
  localparam logic [2:0] BS_T1   = 3'd1;
  localparam logic [2:0] BS_TIW  = 3'd2;
  localparam logic [2:0] BS_T2   = 3'd3;
  localparam logic [2:0] BS_TBW  = 3'd4;
  localparam logic [2:0] BS_T2B  = 3'd5;
  localparam logic [2:0] BS_HOLD = 3'd6;

  function automatic logic [2:0] stateCode(seqState_t s);
    case (s)
      S_T1:    return BS_T1;
      S_TIW:   return BS_TIW;
      S_T2:    return BS_T2;
      S_TBW:   return BS_TBW;
      S_T2B:   return BS_T2B;
      S_HOLD:  return BS_HOLD;
      default: return BS_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/zbus_ctrl.sv
module zbus_ctrl
  import zbus_pkg::*;
#(
  parameter int NUM_ZONES = 4,
  parameter int ZONE_W    = 2,
  parameter int WAIT_W    = 3,
  parameter int HOLD_W    = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [ZONE_W-1:0]           reqZone,
  input  logic                        reqWord,
  output logic                        reqReady,
  input  logic [NUM_ZONES-1:0]        cfgWide,
  input  logic [NUM_ZONES*WAIT_W-1:0] cfgWaits,
  input  logic [NUM_ZONES*HOLD_W-1:0] cfgHolds,
  input  logic [NUM_ZONES-1:0]        cfgBurst,
  input  logic [NUM_ZONES-1:0]        cfgBurstWait,
  input  logic [NUM_ZONES-1:0]        cfgIdlePre,
  input  logic [NUM_ZONES-1:0]        cfgIdlePost,
  output logic [NUM_ZONES-1:0]        zoneSel,
  output logic                        rdStrobe,
  output logic [2:0]                  busState,
  output logic                        rspDone,
  output dpCtl_t                      dpCtl
);

  localparam int CNT_W = (WAIT_W > HOLD_W) ? WAIT_W : HOLD_W;

  seqState_t         st, stNext;
  logic [CNT_W-1:0]  cnt, cntNext;
  logic [ZONE_W-1:0] curZone;
  logic              curWord;
  logic              doneQ;

  logic [WAIT_W-1:0] curWaits;
  logic [HOLD_W-1:0] curHolds;
  logic              needBurst, lastSt, accept, gapNeeded, active;

  assign curWaits  = cfgWaits[int'(curZone)*WAIT_W +: WAIT_W];
  assign curHolds  = cfgHolds[int'(curZone)*HOLD_W +: HOLD_W];
  assign needBurst = curWord && !cfgWide[curZone] && cfgBurst[curZone];

  assign lastSt = (st == S_T2  && !needBurst && curHolds == '0) ||
                  (st == S_T2B && curHolds == '0) ||
                  (st == S_HOLD && cnt == '0);

  assign reqReady  = (st == S_IDLE) || lastSt;
  assign accept    = reqValid && reqReady;
  assign gapNeeded = (st != S_IDLE) && (reqZone != curZone) &&
                     (cfgIdlePost[curZone] || cfgIdlePre[reqZone]);

  always_comb begin
    stNext  = st;
    cntNext = cnt;
    dpCtl   = '0;
    case (st)
      S_IDLE: stNext = S_IDLE;
      S_GAP:  stNext = S_T1;
      S_T1: begin
        if (curWaits != '0) begin
          stNext  = S_TIW;
          cntNext = CNT_W'(curWaits) - 1'b1;
        end else begin
          stNext = S_T2;
        end
      end
      S_TIW: begin
        if (cnt == '0) stNext = S_T2;
        else           cntNext = cnt - 1'b1;
      end
      S_T2: begin
        dpCtl.capLow  = 1'b1;
        dpCtl.capWide = cfgWide[curZone] && curWord;
        if (needBurst) begin
          dpCtl.incAddr = 1'b1;
          stNext = cfgBurstWait[curZone] ? S_TBW : S_T2B;
        end else if (curHolds != '0) begin
          stNext  = S_HOLD;
          cntNext = CNT_W'(curHolds) - 1'b1;
        end
      end
      S_TBW: stNext = S_T2B;
      S_T2B: begin
        dpCtl.capHigh = 1'b1;
        if (curHolds != '0) begin
          stNext  = S_HOLD;
          cntNext = CNT_W'(curHolds) - 1'b1;
        end
      end
      S_HOLD: if (cnt != '0) cntNext = cnt - 1'b1;
      default: stNext = S_IDLE;
    endcase
    if (lastSt) stNext = S_IDLE;
    if (accept) begin
      dpCtl.loadReq = 1'b1;
      stNext = gapNeeded ? S_GAP : S_T1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= S_IDLE;
      cnt     <= '0;
      curZone <= '0;
      curWord <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      st    <= stNext;
      cnt   <= cntNext;
      doneQ <= lastSt;
      if (accept) begin
        curZone <= reqZone;
        curWord <= reqWord;
      end
    end
  end

  assign active   = (st != S_IDLE) && (st != S_GAP);
  assign rdStrobe = (st == S_TIW) || (st == S_T2) || (st == S_TBW) || (st == S_T2B);
  assign busState = stateCode(st);
  assign rspDone  = doneQ;

  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_sel
    assign zoneSel[z] = active && (int'(curZone) == z);
  end

  AST_STROBE_AFTER_T2: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_T2 && !needBurst) |=> !rdStrobe);                                 // R2
  AST_STROBE_AFTER_T2B: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_T2B) |=> !rdStrobe);                                              // R2
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(zoneSel));                                                        // R3
  AST_TBW_THEN_T2B: assert property (@(posedge clk) disable iff (!rstN)
    (busState == BS_TBW) |=> (busState == BS_T2B));                            // R4
  AST_GAP_IS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (accept && gapNeeded) |=> (zoneSel == '0 && busState == BS_IDLE));         // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);                                                     // R9

endmodule

// File: rtl/zbus_datapath.sv
module zbus_datapath
  import zbus_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       busData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [15:0]       rspData
);

  logic [ADDR_W-1:0] addrReg;
  logic [15:0]       dataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (dpCtl.loadReq)      addrReg <= reqAddr;
      else if (dpCtl.incAddr) addrReg <= addrReg + 1'b1;
      if (dpCtl.capLow)       dataReg <= dpCtl.capWide ? busData : {8'h00, busData[7:0]};
      if (dpCtl.capHigh)      dataReg[15:8] <= busData[7:0];
    end
  end

  assign busAddr = addrReg;
  assign rspData = dataReg;

  AST_BURST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.incAddr |=> (busAddr == ADDR_W'($past(busAddr) + 1'b1)));            // R5
  AST_HIGH_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.capHigh |=> (rspData[7:0] == $past(rspData[7:0])));                  // R6

endmodule

// File: rtl/zbus_read_seq.sv
module zbus_read_seq
  import zbus_pkg::*;
#(
  parameter int NUM_ZONES = 4,
  parameter int ZONE_W    = $clog2(NUM_ZONES),
  parameter int ADDR_W    = 21,
  parameter int WAIT_W    = 3,
  parameter int HOLD_W    = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [ZONE_W-1:0]           reqZone,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic                        reqWord,
  output logic                        reqReady,
  input  logic [NUM_ZONES-1:0]        cfgWide,
  input  logic [NUM_ZONES*WAIT_W-1:0] cfgWaits,
  input  logic [NUM_ZONES*HOLD_W-1:0] cfgHolds,
  input  logic [NUM_ZONES-1:0]        cfgBurst,
  input  logic [NUM_ZONES-1:0]        cfgBurstWait,
  input  logic [NUM_ZONES-1:0]        cfgIdlePre,
  input  logic [NUM_ZONES-1:0]        cfgIdlePost,
  output logic [ADDR_W-1:0]           busAddr,
  output logic [NUM_ZONES-1:0]        zoneSel,
  output logic                        rdStrobe,
  output logic [2:0]                  busState,
  input  logic [15:0]                 busData,
  output logic [15:0]                 rspData,
  output logic                        rspDone
);

  dpCtl_t dpCtl;

  zbus_ctrl #(
    .NUM_ZONES(NUM_ZONES), .ZONE_W(ZONE_W), .WAIT_W(WAIT_W), .HOLD_W(HOLD_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqZone(reqZone), .reqWord(reqWord), .reqReady(reqReady),
    .cfgWide(cfgWide), .cfgWaits(cfgWaits), .cfgHolds(cfgHolds),
    .cfgBurst(cfgBurst), .cfgBurstWait(cfgBurstWait),
    .cfgIdlePre(cfgIdlePre), .cfgIdlePost(cfgIdlePost),
    .zoneSel(zoneSel), .rdStrobe(rdStrobe), .busState(busState),
    .rspDone(rspDone), .dpCtl(dpCtl)
  );

  zbus_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .reqAddr(reqAddr),
    .busData(busData), .busAddr(busAddr), .rspData(rspData)
  );

endmodule

// File: tb/zbus_read_seq_bench.sv
module zbus_read_seq_bench;

  localparam int NZ = 4, ZW = 2, AW = 21, WW = 3, HW = 2;
  localparam int NREQ = 80;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, reqValid, reqWord, reqReady, rdStrobe, rspDone;
  logic [ZW-1:0] reqZone;
  logic [AW-1:0] reqAddr, busAddr;
  logic [NZ-1:0] cfgWide, cfgBurst, cfgBurstWait, cfgIdlePre, cfgIdlePost, zoneSel;
  logic [NZ*WW-1:0] cfgWaits;
  logic [NZ*HW-1:0] cfgHolds;
  logic [2:0] busState;
  logic [15:0] busData, rspData;

  // zone shapes
  int wideT[NZ]  = '{1, 0, 0, 0};
  int waitT[NZ]  = '{0, 2, 1, 0};
  int holdT[NZ]  = '{0, 1, 0, 2};
  int burstT[NZ] = '{0, 1, 1, 0};
  int bwT[NZ]    = '{0, 1, 0, 0};
  int preT[NZ]   = '{0, 0, 1, 0};
  int postT[NZ]  = '{0, 1, 0, 0};

  zbus_read_seq #(.NUM_ZONES(NZ), .ZONE_W(ZW), .ADDR_W(AW), .WAIT_W(WW), .HOLD_W(HW)) u_zbus_read_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqZone(reqZone), .reqAddr(reqAddr),
    .reqWord(reqWord), .reqReady(reqReady), .cfgWide(cfgWide), .cfgWaits(cfgWaits),
    .cfgHolds(cfgHolds), .cfgBurst(cfgBurst), .cfgBurstWait(cfgBurstWait),
    .cfgIdlePre(cfgIdlePre), .cfgIdlePost(cfgIdlePost), .busAddr(busAddr),
    .zoneSel(zoneSel), .rdStrobe(rdStrobe), .busState(busState), .busData(busData),
    .rspData(rspData), .rspDone(rspDone)
  );

  function automatic logic [7:0] lowByte(logic [AW-1:0] a);
    return a[7:0] + 8'h11;
  endfunction
  function automatic logic [7:0] highByte(logic [AW-1:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  assign busData = {highByte(busAddr), lowByte(busAddr)};

  typedef struct {
    int            code;
    int            zone;
    bit            selOn;
    bit            strobe;
    bit            chkAddr;
    logic [AW-1:0] addr;
    bit            last;
    logic [15:0]   data;
    string         tag;
  } rec_t;

  rec_t q[$];
  int vectors = 0, errors = 0;
  bit expDone = 0;
  logic [15:0] expData = '0;

  task automatic check(string tag, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic pushRead(int z, logic [AW-1:0] a, bit w, bit gap);
    rec_t r;
    bit nb = w && wideT[z] == 0 && burstT[z] == 1;
    logic [15:0] d;
    logic [AW-1:0] a1 = a + 1'b1;
    if (wideT[z] == 1 && w) d = {highByte(a), lowByte(a)};
    else if (nb)             d = {lowByte(a1), lowByte(a)};
    else                     d = {8'h00, lowByte(a)};
    r.zone = z; r.data = d; r.last = 0; r.addr = a;
    if (gap) begin
      r.code = 0; r.selOn = 0; r.strobe = 0; r.chkAddr = 0; r.tag = "R8";
      q.push_back(r);
    end
    r.selOn = 1; r.chkAddr = 1;
    r.code = 1; r.strobe = 0; r.tag = "R1"; q.push_back(r);
    for (int i = 0; i < waitT[z]; i++) begin
      r.code = 2; r.strobe = 1; r.tag = "R1"; q.push_back(r);
    end
    r.code = 3; r.strobe = 1; r.tag = "R1"; r.last = !nb && holdT[z] == 0; q.push_back(r);
    if (nb) begin
      r.addr = a1; r.last = 0;
      if (bwT[z] == 1) begin r.code = 4; r.tag = "R4"; q.push_back(r); end
      r.code = 5; r.tag = "R4"; r.last = holdT[z] == 0; q.push_back(r);
    end
    for (int i = 0; i < holdT[z]; i++) begin
      r.code = 6; r.strobe = 0; r.tag = "R7"; r.last = (i == holdT[z] - 1); q.push_back(r);
    end
  endtask

  task automatic compareCycle();
    rec_t c;
    bit busy = q.size() > 0;
    if (busy) c = q[0];
    else begin
      c.code = 0; c.selOn = 0; c.strobe = 0; c.chkAddr = 0; c.last = 0; c.zone = 0; c.tag = "R9";
    end
    check(c.tag, "busState", busState, c.code);
    check("R3", "zoneSel", zoneSel, c.selOn ? (1 << c.zone) : 0);
    check("R2", "rdStrobe", rdStrobe, c.strobe);
    if (c.chkAddr) check("R5", "busAddr", busAddr, c.addr);
    check("R9", "reqReady", reqReady, !busy || c.last);
    check("R9", "rspDone", rspDone, expDone);
    if (expDone) check("R6", "rspData", rspData, expData);
  endtask

  initial begin
    int reqIdx = 0, spacing = 0, cycles = 0, lastZone = 0;
    logic [15:0] lfsr = 16'hACE1;
    rstN = 0; reqValid = 0; reqZone = '0; reqAddr = '0; reqWord = 0;
    for (int z = 0; z < NZ; z++) begin
      cfgWide[z] = wideT[z][0]; cfgBurst[z] = burstT[z][0]; cfgBurstWait[z] = bwT[z][0];
      cfgIdlePre[z] = preT[z][0]; cfgIdlePost[z] = postT[z][0];
      cfgWaits[z*WW +: WW] = WW'(waitT[z]); cfgHolds[z*HW +: HW] = HW'(holdT[z]);
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      // R10 reset state
      check("R10", "busState", busState, 0);
      check("R10", "zoneSel", zoneSel, 0);
      check("R10", "rdStrobe", rdStrobe, 0);
      check("R10", "rspDone", rspDone, 0);
      check("R10", "reqReady", reqReady, 1);
    end
    rstN = 1;
    while (reqIdx < NREQ || q.size() > 0 || expDone) begin
      bit busy, rdy, acc;
      int z; logic [AW-1:0] a; bit w;
      rec_t done;
      @(negedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL R9 watchdog: actual %0d requests left expected 0", NREQ - reqIdx);
        break;
      end
      compareCycle();
      busy = q.size() > 0;
      rdy  = !busy || q[0].last;
      // pick stimulus: directed start, then pseudo-random
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (reqIdx)
        0: begin z = 0; w = 1; end 1: begin z = 0; w = 0; end
        2: begin z = 1; w = 1; end 3: begin z = 1; w = 1; end
        4: begin z = 2; w = 1; end 5: begin z = 2; w = 0; end
        6: begin z = 3; w = 1; end 7: begin z = 0; w = 1; end
        8: begin z = 2; w = 1; end 9: begin z = 3; w = 0; end
        default: begin z = int'(lfsr[1:0]); w = lfsr[2]; end
      endcase
      a = AW'(32'h0100 + reqIdx * 5 + ((reqIdx == 3) ? 32'hFF : 0));
      acc = 0;
      if (reqIdx < NREQ && spacing == 0) begin
        reqValid = 1; reqZone = ZW'(z); reqAddr = a; reqWord = w;
        acc = rdy;
      end else begin
        reqValid = 0;
        if (spacing > 0) spacing--;
      end
      expDone = 0;
      if (busy) begin
        done = q.pop_front();
        if (done.last) begin expDone = 1; expData = done.data; end
      end
      if (acc) begin
        pushRead(z, a, w, busy && z != lastZone && (postT[lastZone] == 1 || preT[z] == 1));
        lastZone = z;
        reqIdx++;
        if (reqIdx % 7 == 0) spacing = 4;
        else if (reqIdx % 5 == 0) spacing = 1;
      end
    end
    @(negedge clk);
    reqValid = 0;
    check("R9", "idle busState", busState, 0);
    check("R3", "idle zoneSel", zoneSel, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule